// File: doc/BRIEF.md
# Four-beat pipelined read burst checker

This block watches the command and response wires of a master/slave core interface and recognises a complete four-beat read burst. The master's request beats carry a read command, an address and a one-hot "beats remaining" code that counts down from four to one. The first two request beats go out alone. The last two request beats overlap with the first two response beats. The final two response beats then follow on their own. The checker steps through seven states, from ST_IDLE (0) through ST_END (6). It keeps a small scoreboard of the request beats it has seen, and each response beat is accepted only if the scoreboard holds the request beat that must come before it.

Each state's accepting beat:

- ST_IDLE (0) waits for the opening request.
- ST_A1 (1) has the opening request accepted.
- ST_A2 (2) has the second request seen.
- ST_A3R1 (3) has the third request and the first response seen.
- ST_A4R2 (4) has the fourth request and the second response seen.
- ST_R3 (5) has the third response seen.
- ST_END (6) means the burst completed.

A beat that breaks the sequence either restarts the burst, if it is itself a valid opening request, or drops the checker back to idle with a one-cycle error flag. A done flag marks every completed burst, and the state index is brought out for debug.

Top module: `burst_mon_top`

## Requirements
- R1: A synchronous active-high `rst` puts the checker in ST_IDLE (state 0) with an empty scoreboard. `burst_done` and `proto_err` are low on the cycle after reset.
- R2: The opening beat is `rd_cmd`, `remain[3]` (bit 3 means four beats remain), `addr_vld` and `cmd_acc`, all high in one cycle. In ST_IDLE this beat moves the checker to ST_A1 on the next edge and records the command and count four. If any of the four is missing, the checker stays in state 0 with no error.
- R3: In ST_A1, a beat with `rd_cmd`, `remain[2]` (three remain) and `addr_vld` moves the checker to ST_A2 and records count three.
- R4: In ST_A2, the checker moves to ST_A3R1 on a beat with `rd_cmd`, `remain[1]` (two remain), `addr_vld`, `resp_vld` and `data_vld`. The scoreboard must hold the command and count four. The move records count two.
- R5: In ST_A3R1, the checker moves to ST_A4R2 on a beat with `rd_cmd`, `remain[0]` (one remains), `addr_vld`, `resp_vld` and `data_vld`. The scoreboard must hold the command and count three. The move records count one.
- R6: The remaining moves need `resp_vld` and `data_vld` only. ST_A4R2 moves to ST_R3 when the command and count two are recorded. ST_R3 moves to ST_END when the command and count one are recorded, and that move empties the scoreboard.
- R7: `burst_done` is high for exactly the one cycle the checker sits in ST_END, which is the cycle after the last response beat.
- R8: In states 1 to 5, if the expected beat is missing but an opening beat is present, the checker clears every scoreboard entry, records the command and count four again, and moves to ST_A1. If the expected beat and an opening beat arrive together, the expected beat wins.
- R9: In states 1 to 5, any other beat moves the checker to state 0 and empties the scoreboard. `proto_err` goes high for that one following cycle.
- R10: ST_END always leaves after one cycle. It goes to ST_A1 if an opening beat is present, so back-to-back bursts are counted, and to ST_IDLE with no error otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_cmd | input | 1 | Read command present |
| remain | input | 4 | One-hot beats remaining, bit k means k+1 beats remain |
| addr_vld | input | 1 | Address valid |
| cmd_acc | input | 1 | Slave accepts the command |
| resp_vld | input | 1 | Response valid |
| data_vld | input | 1 | Read data valid |
| burst_done | output | 1 | Burst completed (high in ST_END) |
| proto_err | output | 1 | Sequence broken, one-cycle pulse |
| state_idx | output | 3 | Current state number 0..6 |

## Verification
A wrong state or a lost scoreboard bit shows up at the ports one edge after the beat that was taken wrongly. The state index diverges at once. A missing record stalls the next response beat, which turns a later step into `proto_err` one or two beats further on. The bench therefore compares `state_idx`, `burst_done` and `proto_err` with a behavioural model on every cycle. It covers:

- clean bursts;
- back-to-back bursts;
- restarts from several states, including an opening beat that coincides with an expected response beat;
- errors in the request-only and the overlapping phases.

// File: rtl/burst_mon_pkg.sv
package burst_mon_pkg;

    localparam int BEATS = 4;
    localparam int ST_W  = $clog2(BEATS + 3);

    typedef enum logic [ST_W-1:0] {
        ST_IDLE = 3'd0,
        ST_A1   = 3'd1,
        ST_A2   = 3'd2,
        ST_A3R1 = 3'd3,
        ST_A4R2 = 3'd4,
        ST_R3   = 3'd5,
        ST_END  = 3'd6
    } mon_state_t;

    // cnt[k] set means the request beat with k+1 beats remaining was seen
    typedef struct packed {
        logic             cmd;
        logic [BEATS-1:0] cnt;
    } sb_t;

endpackage

// File: rtl/burst_mon_beat.sv
module burst_mon_beat
    import burst_mon_pkg::*;
(
    input  logic             rd_cmd,
    input  logic [BEATS-1:0] remain,
    input  logic             addr_vld,
    input  logic             cmd_acc,
    input  logic             resp_vld,
    input  logic             data_vld,
    output logic             first_hit,
    output logic [BEATS-1:0] req_hit,
    output logic             rsp_hit
);

    for (genvar k = 0; k < BEATS; k++) begin : g_req
        assign req_hit[k] = rd_cmd & remain[k] & addr_vld;
    end

    assign first_hit = req_hit[BEATS-1] & cmd_acc;
    assign rsp_hit   = resp_vld & data_vld;

endmodule

// File: rtl/burst_mon_sb.sv
module burst_mon_sb
    import burst_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             set_cmd,
    input  logic [BEATS-1:0] set_cnt,
    output sb_t              q
);

    sb_t d;

    always_comb begin
        d      = clr ? '0 : q;
        d.cmd  = d.cmd | set_cmd;
        d.cnt  = d.cnt | set_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    AST_SB_SET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (set_cnt != '0) |=> ((q.cnt & $past(set_cnt)) == $past(set_cnt))); // R8

endmodule

// File: rtl/burst_mon_top.sv
module burst_mon_top
    import burst_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_cmd,
    input  logic [3:0] remain,
    input  logic       addr_vld,
    input  logic       cmd_acc,
    input  logic       resp_vld,
    input  logic       data_vld,
    output logic       burst_done,
    output logic       proto_err,
    output logic [2:0] state_idx
);

    mon_state_t       state, nxt;
    sb_t              sb_q;
    logic             first_hit, rsp_hit;
    logic [BEATS-1:0] req_hit;
    logic             sb_clr, set_cmd, abandon, err_d, done_d;
    logic [BEATS-1:0] set_cnt;

    burst_mon_beat u_beat (
        .rd_cmd    (rd_cmd),
        .remain    (remain),
        .addr_vld  (addr_vld),
        .cmd_acc   (cmd_acc),
        .resp_vld  (resp_vld),
        .data_vld  (data_vld),
        .first_hit (first_hit),
        .req_hit   (req_hit),
        .rsp_hit   (rsp_hit)
    );

    burst_mon_sb u_sb (
        .clk     (clk),
        .rst     (rst),
        .clr     (sb_clr),
        .set_cmd (set_cmd),
        .set_cnt (set_cnt),
        .q       (sb_q)
    );

    // next state and scoreboard actions
    always_comb begin
        nxt     = state;
        sb_clr  = 1'b0;
        set_cmd = 1'b0;
        set_cnt = '0;
        abandon = 1'b0;
        err_d   = 1'b0;
        done_d  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (first_hit) begin
                    nxt     = ST_A1;
                    set_cmd = 1'b1;
                    set_cnt[BEATS-1] = 1'b1;
                end
            end
            ST_A1: begin
                if (req_hit[2]) begin
                    nxt        = ST_A2;
                    set_cmd    = 1'b1;
                    set_cnt[2] = 1'b1;
                end else abandon = 1'b1;
            end
            ST_A2: begin
                if (req_hit[1] && rsp_hit && sb_q.cmd && sb_q.cnt[3]) begin
                    nxt        = ST_A3R1;
                    set_cnt[1] = 1'b1;
                end else abandon = 1'b1;
            end
            ST_A3R1: begin
                if (req_hit[0] && rsp_hit && sb_q.cmd && sb_q.cnt[2]) begin
                    nxt        = ST_A4R2;
                    set_cnt[0] = 1'b1;
                end else abandon = 1'b1;
            end
            ST_A4R2: begin
                if (rsp_hit && sb_q.cmd && sb_q.cnt[1]) nxt = ST_R3;
                else abandon = 1'b1;
            end
            ST_R3: begin
                if (rsp_hit && sb_q.cmd && sb_q.cnt[0]) begin
                    nxt    = ST_END;
                    sb_clr = 1'b1;
                    done_d = 1'b1;
                end else abandon = 1'b1;
            end
            ST_END: begin
                if (first_hit) begin
                    nxt     = ST_A1;
                    set_cmd = 1'b1;
                    set_cnt[BEATS-1] = 1'b1;
                end else nxt = ST_IDLE;
            end
            default: begin
                nxt    = ST_IDLE;
                sb_clr = 1'b1;
            end
        endcase
        if (abandon) begin
            sb_clr = 1'b1;
            if (first_hit) begin
                nxt     = ST_A1;
                set_cmd = 1'b1;
                set_cnt[BEATS-1] = 1'b1;
            end else begin
                nxt   = ST_IDLE;
                err_d = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            burst_done <= 1'b0;
            proto_err  <= 1'b0;
        end else begin
            burst_done <= done_d;
            proto_err  <= err_d;
        end
    end

    assign state_idx = state;

    AST_FIRST_ARMS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && first_hit) |=> (state == ST_A1)); // R2
    AST_OVL_GATED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_A3R1) |-> (sb_q.cmd && sb_q.cnt[3] && sb_q.cnt[2])); // R4
    AST_DONE_AFTER_R3: assert property (@(posedge clk) disable iff (rst)
        burst_done |-> ($past(state) == ST_R3)); // R7
    AST_DONE_IN_END: assert property (@(posedge clk) disable iff (rst)
        burst_done |-> (state == ST_END)); // R7
    AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> (state == ST_IDLE)); // R9
    AST_IDLE_SB_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (sb_q == '0)); // R9
    AST_END_SB_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_END) |-> (sb_q == '0)); // R10
    AST_NO_DONE_ERR: assert property (@(posedge clk) disable iff (rst)
        !(burst_done && proto_err)); // R7

endmodule

// File: tb/tb_burst_mon_top.sv
`timescale 1ns/1ps
module tb_burst_mon_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       rd_cmd, addr_vld, cmd_acc, resp_vld, data_vld;
    logic [3:0] remain;
    logic       burst_done, proto_err;
    logic [2:0] state_idx;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // behavioural reference
    int m_st;
    int m_done, m_err;
    bit m_cmd;
    bit m_c[1:4];

    always #4 clk = ~clk;

    burst_mon_top dut (
        .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .remain(remain),
        .addr_vld(addr_vld), .cmd_acc(cmd_acc), .resp_vld(resp_vld),
        .data_vld(data_vld), .burst_done(burst_done), .proto_err(proto_err),
        .state_idx(state_idx)
    );

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    task automatic m_clear();
        m_cmd = 0;
        for (int k = 1; k <= 4; k++) m_c[k] = 0;
    endtask

    task automatic m_open();
        m_clear();
        m_cmd  = 1;
        m_c[4] = 1;
        m_st   = 1;
    endtask

    task automatic model(input bit rd, input bit [3:0] rem, input bit ad,
                         input bit ac, input bit rs, input bit dt);
        bit first, rsp, ok;
        first  = rd && rem[3] && ad && ac;
        rsp    = rs && dt;
        ok     = 0;
        m_done = 0;
        m_err  = 0;
        case (m_st)
            0: if (first) m_open();
            6: if (first) m_open(); else m_st = 0;
            default: begin
                case (m_st)
                    1: ok = rd && rem[2] && ad;
                    2: ok = rd && rem[1] && ad && rsp && m_cmd && m_c[4];
                    3: ok = rd && rem[0] && ad && rsp && m_cmd && m_c[3];
                    4: ok = rsp && m_cmd && m_c[2];
                    5: ok = rsp && m_cmd && m_c[1];
                    default: ok = 0;
                endcase
                if (ok) begin
                    if (m_st == 1) begin m_cmd = 1; m_c[3] = 1; end
                    if (m_st == 2) m_c[2] = 1;
                    if (m_st == 3) m_c[1] = 1;
                    if (m_st == 5) begin m_clear(); m_done = 1; end
                    m_st = m_st + 1;
                end else if (first) begin
                    m_open();
                end else begin
                    m_clear();
                    m_st  = 0;
                    m_err = 1;
                end
            end
        endcase
    endtask

    task automatic compare(input string tag);
        n_chk++;
        if (state_idx !== 3'(m_st) || burst_done !== 1'(m_done) || proto_err !== 1'(m_err)) begin
            n_bad++;
            $display("FAIL %s: actual st=%0d done=%0b err=%0b expected st=%0d done=%0d err=%0d",
                     tag, state_idx, burst_done, proto_err, m_st, m_done, m_err);
        end
    endtask

    task automatic beat(input bit rd, input bit [3:0] rem, input bit ad,
                        input bit ac, input bit rs, input bit dt, input string tag);
        rd_cmd = rd; remain = rem; addr_vld = ad;
        cmd_acc = ac; resp_vld = rs; data_vld = dt;
        @(posedge clk);
        #1;
        model(rd, rem, ad, ac, rs, dt);
        compare(tag);
    endtask

    task automatic b_first(input string t); beat(1, 4'b1000, 1, 1, 0, 0, t); endtask
    task automatic b_req3(input string t);  beat(1, 4'b0100, 1, 0, 0, 0, t); endtask
    task automatic b_ovl2(input string t);  beat(1, 4'b0010, 1, 0, 1, 1, t); endtask
    task automatic b_ovl1(input string t);  beat(1, 4'b0001, 1, 0, 1, 1, t); endtask
    task automatic b_rsp(input string t);   beat(0, 4'b0000, 0, 0, 1, 1, t); endtask
    task automatic b_idle(input string t);  beat(0, 4'b0000, 0, 0, 0, 0, t); endtask

    task automatic burst(input string t);
        b_first(t); b_req3(t); b_ovl2(t); b_ovl1(t); b_rsp(t); b_rsp(t);
    endtask

    initial begin
        rst = 1'b1;
        rd_cmd = 0; remain = 0; addr_vld = 0; cmd_acc = 0; resp_vld = 0; data_vld = 0;
        m_st = 0; m_done = 0; m_err = 0; m_clear();
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        compare("R1");

        // opening beat incomplete: stays idle
        b_idle("R2");
        beat(1, 4'b1000, 1, 0, 0, 0, "R2");
        beat(1, 4'b1000, 0, 1, 0, 0, "R2");
        beat(0, 4'b1000, 1, 1, 0, 0, "R2");

        // clean burst
        b_first("R2"); b_req3("R3"); b_ovl2("R4"); b_ovl1("R5");
        b_rsp("R6"); b_rsp("R7"); b_idle("R7");

        // back-to-back bursts
        burst("R10"); burst("R10"); b_idle("R10");

        // restarts
        b_first("R8"); b_first("R8"); b_req3("R8"); b_ovl2("R8");
        b_first("R8"); b_req3("R8"); b_ovl2("R8"); b_ovl1("R8");
        b_first("R8"); b_req3("R8"); b_ovl2("R8"); b_ovl1("R8"); b_rsp("R8");
        beat(1, 4'b1000, 1, 1, 1, 1, "R8");
        b_req3("R10");

        // protocol errors
        b_first("R9"); b_idle("R9"); b_idle("R9");
        b_first("R3"); beat(1, 4'b0010, 1, 0, 0, 0, "R3"); b_idle("R9");
        b_first("R9"); b_req3("R9"); beat(1, 4'b0010, 1, 0, 0, 0, "R9");
        b_first("R5"); b_req3("R5"); b_ovl2("R5"); beat(1, 4'b0001, 1, 0, 1, 0, "R5");
        b_first("R6"); b_req3("R6"); b_ovl2("R6"); b_ovl1("R6"); b_rsp("R6"); b_idle("R6");
        b_first("R4"); b_req3("R4"); beat(1, 4'b0010, 1, 0, 0, 1, "R4");

        // reset in mid burst
        b_first("R1"); b_req3("R1");
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        m_st = 0; m_done = 0; m_err = 0; m_clear();
        compare("R1");
        b_ovl2("R1");

        summary();
        $finish;
    end

endmodule